// File: doc/BRIEF.md
# Multi-Cycle Processor Control Sequencer

This block is the control unit of a processor that spreads each instruction over several short clock cycles and shares one memory and one ALU between all of them. It is a Moore state machine: every control strobe and multiplexer select depends only on the current step. The only input it uses is the 6-bit opcode held in the datapath's instruction register.

Every instruction starts with two shared steps. The first fetches the instruction and advances the PC. The second decodes it and stores a precomputed branch target. After that each instruction class follows its own short path and then returns to fetch. The supported classes are register-register ALU operations, word load, word store, branch-if-equal and jump. An opcode the sequencer does not know sends it straight back to fetch, and no write of any kind is made for it.

Reset is an asynchronous active-low input. It forces the fetch step at once. The release is synchronised, so the sequencer leaves fetch on the third rising clock edge after `rst_n` goes high.

Top module: `mcc_ctrl_fsm`

## Requirements
- R1: While reset is applied, and until the second rising edge after its release, the outputs show the fetch step: memory read, IR load and PC load are 1, ALU B select is 01 (constant four), and every other output is 0.
- R2: The step after fetch is always decode, whatever the opcode. Decode drives ALU B select 11 (shifted immediate), ALU function 00 (add) and target-register load, with every other output 0.
- R3: Load (opcode 0x23) runs address, memory-read and write-back steps, then returns to fetch. All three steps hold ALU A from register, B select 10 (sign-extended immediate), function add and memory address from ALU. The read step adds memory read. Write-back adds memory read, write data from memory, destination from the rt field (select 0) and register-file write.
- R4: Store (opcode 0x2B) runs the address step, then a step that holds the address settings and adds memory write, then returns to fetch.
- R5: An ALU instruction (opcode 0x00) runs an execute step with ALU A from register, B select 00 (register B) and function 10 (from the funct field). It then runs a completion step that adds destination from the rd field (select 1) and register-file write, and then returns to fetch.
- R6: Branch-if-equal (opcode 0x04) runs one step with ALU A from register, B select 00, function 01 (subtract), PC source 01 (target register) and conditional PC load, then returns to fetch.
- R7: Jump (opcode 0x02) runs one step with PC load and PC source 10 (jump address), then returns to fetch.
- R8: Any other opcode seen in decode returns to fetch on the next edge, with no memory, register-file or PC write in between.
- R9: Memory read and memory write are never 1 in the same cycle.
- R10: The opcode is sampled only at the end of decode and of the address step. Its value in all other steps has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode_i | input | 6 | Opcode field from the instruction register |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| ir_ld_o | output | 1 | Instruction register load |
| addr_from_alu_o | output | 1 | Memory address from ALU (1) or PC (0) |
| alu_a_reg_o | output | 1 | ALU A from register (1) or PC (0) |
| alu_b_sel_o | output | 2 | ALU B: 00 reg, 01 four, 10 imm, 11 imm shifted |
| alu_fn_o | output | 2 | 00 add, 01 subtract, 10 from funct |
| pc_src_o | output | 2 | 00 ALU, 01 target register, 10 jump address |
| pc_ld_o | output | 1 | Unconditional PC load |
| pc_ld_if_eq_o | output | 1 | PC load when ALU result is zero |
| tgt_ld_o | output | 1 | Branch-target register load |
| wr_dst_rd_o | output | 1 | Destination from rd (1) or rt (0) |
| wb_from_mem_o | output | 1 | Write data from memory (1) or ALU (0) |
| rf_wr_o | output | 1 | Register-file write |

## Verification
Two functions can fall in the same cycle. The first is the opcode-driven choice of path, made in decode and in the address step. The second is the hold of outputs in every other step, while the opcode input is free to change. The bench drives the real opcode only through fetch, decode and the address step, and drives random values during all later steps. A reference model that reads the opcode only where the requirements allow then judges every output on every cycle. A reset asserted in the middle of an ALU completion step also checks that the asynchronous return to fetch wins over the running sequence.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

  localparam int OPC_W = 6;

  typedef enum logic [3:0] {
    ST_FETCH  = 4'd0,
    ST_DECODE = 4'd1,
    ST_MADDR  = 4'd2,
    ST_MREAD  = 4'd3,
    ST_LDWB   = 4'd4,
    ST_MWRITE = 4'd5,
    ST_EXEC   = 4'd6,
    ST_RWB    = 4'd7,
    ST_BRANCH = 4'd8,
    ST_JUMP   = 4'd9
  } mcc_state_e;

  typedef struct packed {
    logic       mem_rd;
    logic       mem_wr;
    logic       ir_ld;
    logic       addr_alu;
    logic       a_reg;
    logic [1:0] b_sel;
    logic [1:0] fn;
    logic [1:0] pc_src;
    logic       pc_ld;
    logic       pc_ld_eq;
    logic       tgt_ld;
    logic       dst_rd;
    logic       wb_mem;
    logic       rf_wr;
  } mcc_ctl_t;

  localparam logic [1:0] B_REG   = 2'b00;
  localparam logic [1:0] B_FOUR  = 2'b01;
  localparam logic [1:0] B_IMM   = 2'b10;
  localparam logic [1:0] B_IMMSH = 2'b11;

  localparam logic [1:0] FN_ADD   = 2'b00;
  localparam logic [1:0] FN_SUB   = 2'b01;
  localparam logic [1:0] FN_FUNCT = 2'b10;

  localparam logic [1:0] PCS_ALU = 2'b00;
  localparam logic [1:0] PCS_TGT = 2'b01;
  localparam logic [1:0] PCS_JMP = 2'b10;

endpackage

// File: rtl/mcc_rst_sync.sv
module mcc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  generate
    genvar g;
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= 1'b1;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/mcc_next_state.sv
module mcc_next_state
  import mcc_pkg::*;
#(
  parameter logic [OPC_W-1:0] OPC_ALU   = 6'h00,
  parameter logic [OPC_W-1:0] OPC_LOAD  = 6'h23,
  parameter logic [OPC_W-1:0] OPC_STORE = 6'h2B,
  parameter logic [OPC_W-1:0] OPC_BEQ   = 6'h04,
  parameter logic [OPC_W-1:0] OPC_JUMP  = 6'h02
) (
  input  mcc_state_e       cur_st,
  input  logic [OPC_W-1:0] opcode,
  output mcc_state_e       nxt_st
);
  mcc_state_e dispatch;

  // path chosen at the end of decode
  always_comb begin
    if (opcode == OPC_LOAD || opcode == OPC_STORE) dispatch = ST_MADDR;
    else if (opcode == OPC_ALU)                    dispatch = ST_EXEC;
    else if (opcode == OPC_BEQ)                    dispatch = ST_BRANCH;
    else if (opcode == OPC_JUMP)                   dispatch = ST_JUMP;
    else                                           dispatch = ST_FETCH;
  end

  always_comb begin
    unique case (cur_st)
      ST_FETCH:  nxt_st = ST_DECODE;
      ST_DECODE: nxt_st = dispatch;
      ST_MADDR:  nxt_st = (opcode == OPC_STORE) ? ST_MWRITE : ST_MREAD;
      ST_MREAD:  nxt_st = ST_LDWB;
      ST_EXEC:   nxt_st = ST_RWB;
      default:   nxt_st = ST_FETCH;
    endcase
  end
endmodule

// File: rtl/mcc_out_decode.sv
module mcc_out_decode
  import mcc_pkg::*;
(
  input  mcc_state_e cur_st,
  output mcc_ctl_t   ctl
);
  always_comb begin
    ctl = '0;
    unique case (cur_st)
      ST_FETCH: begin
        ctl.mem_rd = 1'b1;
        ctl.ir_ld  = 1'b1;
        ctl.pc_ld  = 1'b1;
        ctl.b_sel  = B_FOUR;
        ctl.fn     = FN_ADD;
        ctl.pc_src = PCS_ALU;
      end
      ST_DECODE: begin
        ctl.b_sel  = B_IMMSH;
        ctl.fn     = FN_ADD;
        ctl.tgt_ld = 1'b1;
      end
      ST_MADDR, ST_MREAD, ST_LDWB, ST_MWRITE: begin
        ctl.a_reg    = 1'b1;
        ctl.b_sel    = B_IMM;
        ctl.fn       = FN_ADD;
        ctl.addr_alu = 1'b1;
        ctl.mem_rd   = (cur_st == ST_MREAD) || (cur_st == ST_LDWB);
        ctl.mem_wr   = (cur_st == ST_MWRITE);
        ctl.wb_mem   = (cur_st == ST_LDWB);
        ctl.rf_wr    = (cur_st == ST_LDWB);
      end
      ST_EXEC, ST_RWB: begin
        ctl.a_reg  = 1'b1;
        ctl.b_sel  = B_REG;
        ctl.fn     = FN_FUNCT;
        ctl.dst_rd = (cur_st == ST_RWB);
        ctl.rf_wr  = (cur_st == ST_RWB);
      end
      ST_BRANCH: begin
        ctl.a_reg    = 1'b1;
        ctl.b_sel    = B_REG;
        ctl.fn       = FN_SUB;
        ctl.pc_src   = PCS_TGT;
        ctl.pc_ld_eq = 1'b1;
      end
      ST_JUMP: begin
        ctl.pc_ld  = 1'b1;
        ctl.pc_src = PCS_JMP;
      end
      default: ctl = '0;
    endcase
  end

  always_comb begin
    assert_rd_wr_excl_R9: assert (!(ctl.mem_rd && ctl.mem_wr));
  end
endmodule

// File: rtl/mcc_ctrl_fsm.sv
module mcc_ctrl_fsm
  import mcc_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [OPC_W-1:0]  OPC_ALU     = 6'h00,
  parameter logic [OPC_W-1:0]  OPC_LOAD    = 6'h23,
  parameter logic [OPC_W-1:0]  OPC_STORE   = 6'h2B,
  parameter logic [OPC_W-1:0]  OPC_BEQ     = 6'h04,
  parameter logic [OPC_W-1:0]  OPC_JUMP    = 6'h02
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] opcode_i,
  output logic             mem_rd_o,
  output logic             mem_wr_o,
  output logic             ir_ld_o,
  output logic             addr_from_alu_o,
  output logic             alu_a_reg_o,
  output logic [1:0]       alu_b_sel_o,
  output logic [1:0]       alu_fn_o,
  output logic [1:0]       pc_src_o,
  output logic             pc_ld_o,
  output logic             pc_ld_if_eq_o,
  output logic             tgt_ld_o,
  output logic             wr_dst_rd_o,
  output logic             wb_from_mem_o,
  output logic             rf_wr_o
);
  logic       rst_sync_n;
  mcc_state_e state_q;
  mcc_state_e state_d;
  mcc_ctl_t   ctl;

  mcc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mcc_next_state #(
    .OPC_ALU   (OPC_ALU),
    .OPC_LOAD  (OPC_LOAD),
    .OPC_STORE (OPC_STORE),
    .OPC_BEQ   (OPC_BEQ),
    .OPC_JUMP  (OPC_JUMP)
  ) u_next (
    .cur_st (state_q),
    .opcode (opcode_i),
    .nxt_st (state_d)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) state_q <= ST_FETCH;
    else             state_q <= state_d;
  end

  mcc_out_decode u_out (
    .cur_st (state_q),
    .ctl    (ctl)
  );

  assign mem_rd_o        = ctl.mem_rd;
  assign mem_wr_o        = ctl.mem_wr;
  assign ir_ld_o         = ctl.ir_ld;
  assign addr_from_alu_o = ctl.addr_alu;
  assign alu_a_reg_o     = ctl.a_reg;
  assign alu_b_sel_o     = ctl.b_sel;
  assign alu_fn_o        = ctl.fn;
  assign pc_src_o        = ctl.pc_src;
  assign pc_ld_o         = ctl.pc_ld;
  assign pc_ld_if_eq_o   = ctl.pc_ld_eq;
  assign tgt_ld_o        = ctl.tgt_ld;
  assign wr_dst_rd_o     = ctl.dst_rd;
  assign wb_from_mem_o   = ctl.wb_mem;
  assign rf_wr_o         = ctl.rf_wr;

  logic opc_known;
  assign opc_known = (opcode_i == OPC_ALU) || (opcode_i == OPC_LOAD) ||
                     (opcode_i == OPC_STORE) || (opcode_i == OPC_BEQ) ||
                     (opcode_i == OPC_JUMP);

  always @(posedge clk) begin
    if (rst_n && !rst_sync_n)
      assert_hold_fetch_R1: assert (state_q == ST_FETCH && mem_rd_o && ir_ld_o);
  end

  assert_fetch_to_decode_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_FETCH) |=> (state_q == ST_DECODE && tgt_ld_o));

  assert_load_path_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_MREAD) |=> (state_q == ST_LDWB && rf_wr_o && wb_from_mem_o));

  assert_store_done_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_wr_o) |=> (state_q == ST_FETCH));

  assert_alu_path_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_EXEC) |=> (rf_wr_o && wr_dst_rd_o && !wb_from_mem_o));

  assert_branch_done_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pc_ld_if_eq_o) |=> (state_q == ST_FETCH));

  assert_jump_done_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_JUMP) |=> (state_q == ST_FETCH));

  assert_unknown_op_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_DECODE && !opc_known) |=> (state_q == ST_FETCH));

  assert_mem_stable_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_MREAD) |=> $stable(alu_b_sel_o) && $stable(addr_from_alu_o));
endmodule

// File: tb/mcc_ctrl_fsm_tb.sv
module mcc_ctrl_fsm_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] opcode;
  logic       mem_rd, mem_wr, ir_ld, addr_alu, a_reg, pc_ld, pc_eq, tgt_ld;
  logic       dst_rd, wb_mem, rf_wr;
  logic [1:0] b_sel, fn, pc_src;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int m_st   = 0;
  int m_rel  = 0;
  bit started = 0;
  bit garbage = 0;
  bit bad_ret = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  mcc_ctrl_fsm u_dut (
    .clk(clk), .rst_n(rst_n), .opcode_i(opcode),
    .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .ir_ld_o(ir_ld),
    .addr_from_alu_o(addr_alu), .alu_a_reg_o(a_reg), .alu_b_sel_o(b_sel),
    .alu_fn_o(fn), .pc_src_o(pc_src), .pc_ld_o(pc_ld), .pc_ld_if_eq_o(pc_eq),
    .tgt_ld_o(tgt_ld), .wr_dst_rd_o(dst_rd), .wb_from_mem_o(wb_mem), .rf_wr_o(rf_wr)
  );

  // order: rd wr ir addr a b[2] fn[2] pcsrc[2] pcld pceq tgt dst wbmem rfwr
  function automatic logic [16:0] expect_of(int st);
    case (st)
      0: return {1'b1,1'b0,1'b1,1'b0,1'b0,2'b01,2'b00,2'b00,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0};
      1: return {1'b0,1'b0,1'b0,1'b0,1'b0,2'b11,2'b00,2'b00,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0};
      2: return {1'b0,1'b0,1'b0,1'b1,1'b1,2'b10,2'b00,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0};
      3: return {1'b1,1'b0,1'b0,1'b1,1'b1,2'b10,2'b00,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0};
      4: return {1'b1,1'b0,1'b0,1'b1,1'b1,2'b10,2'b00,2'b00,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1};
      5: return {1'b0,1'b1,1'b0,1'b1,1'b1,2'b10,2'b00,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0};
      6: return {1'b0,1'b0,1'b0,1'b0,1'b1,2'b00,2'b10,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0};
      7: return {1'b0,1'b0,1'b0,1'b0,1'b1,2'b00,2'b10,2'b00,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1};
      8: return {1'b0,1'b0,1'b0,1'b0,1'b1,2'b00,2'b01,2'b01,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0};
      9: return {1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,2'b10,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0};
      default: return '0;
    endcase
  endfunction

  function automatic string req_of(int st);
    case (st)
      0: return "R1";
      1: return "R2";
      2, 3, 4: return "R3";
      5: return "R4";
      6, 7: return "R5";
      8: return "R6";
      default: return "R7";
    endcase
  endfunction

  // reference model: step sequence taken from the requirements
  always @(posedge clk) begin
    cycles++;
    started = 1;
    if (!rst_n) begin
      m_st = 0; m_rel = 0; bad_ret = 0;
    end else if (m_rel < 2) begin
      m_rel++; m_st = 0; bad_ret = 0;
    end else begin
      bad_ret = 0;
      case (m_st)
        0: m_st = 1;
        1: begin
          if (opcode == 6'h23 || opcode == 6'h2B) m_st = 2;
          else if (opcode == 6'h00) m_st = 6;
          else if (opcode == 6'h04) m_st = 8;
          else if (opcode == 6'h02) m_st = 9;
          else begin m_st = 0; bad_ret = 1; end
        end
        2: m_st = (opcode == 6'h2B) ? 5 : 3;
        3: m_st = 4;
        6: m_st = 7;
        default: m_st = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (started && !finished) begin
      logic [16:0] got;
      logic [16:0] exp;
      got = {mem_rd, mem_wr, ir_ld, addr_alu, a_reg, b_sel, fn, pc_src,
             pc_ld, pc_eq, tgt_ld, dst_rd, wb_mem, rf_wr};
      exp = expect_of(m_st);
      checks++;
      if (got !== exp) begin
        errors++;
        $display("FAIL %s step %0d: got %b expected %b", req_of(m_st), m_st, got, exp);
      end
      if (bad_ret) begin
        // R8: unknown opcode lands back in fetch with no write strobe
        checks++;
        if (got !== expect_of(0) || mem_wr || rf_wr || pc_eq) begin
          errors++;
          $display("FAIL R8: got %b expected %b", got, expect_of(0));
        end
      end
      if (garbage && m_st >= 3) begin
        // R10: random opcode in late steps must not disturb outputs
        checks++;
        if (got !== exp) begin
          errors++;
          $display("FAIL R10: got %b expected %b", got, exp);
        end
      end
      checks++;
      if (mem_rd && mem_wr) begin
        errors++;
        $display("FAIL R9: rd=%b wr=%b expected not both 1", mem_rd, mem_wr);
      end
    end
  end

  initial begin
    logic [5:0] prog [12];
    logic [5:0] cur;
    int idx;
    bit did_rst;
    prog = '{6'h23, 6'h2B, 6'h00, 6'h04, 6'h02, 6'h3F,
             6'h23, 6'h01, 6'h2B, 6'h00, 6'h04, 6'h08};
    idx = 0; did_rst = 0; cur = 6'h00;
    rst_n = 1'b0;
    opcode = 6'h00;
    repeat (4) @(negedge clk);
    #2 rst_n = 1'b1;
    while (!(idx >= 240 && m_st == 0 && m_rel == 2)) begin
      @(negedge clk);
      #2;
      if (!did_rst && idx >= 120 && m_st == 7) begin
        // R1: reset in the middle of ALU completion
        rst_n = 1'b0; m_st = 0; m_rel = 0;
        did_rst = 1;
        repeat (3) @(negedge clk);
        #2 rst_n = 1'b1;
      end else begin
        if (m_rel == 2 && m_st == 0) begin
          cur = prog[idx % 12];
          idx++;
        end
        if (m_st <= 2) begin
          opcode = cur; garbage = 0;
        end else begin
          opcode = 6'($urandom()); garbage = 1;
        end
      end
    end
    repeat (2) @(negedge clk);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: got cycles %0d expected under 20000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule